// File: doc/BRIEF.md
# Serial Port Control and Status Register File

This block is the processor-side register front end of a serial port that has a receive FIFO. A simple single-beat access port (enable, write select, word address, write data) reaches ten word-aligned register slots: mode, bit rate, control, transmit data, status, receive data, FIFO control, FIFO count, port and line status. Read data returns one cycle after the access, together with a valid strobe. Side effects of a read, such as a receive pop or the re-arming of the transmit flags, take place on the same clock edge that captures the returned value.

The block holds five status flags: transmit-end, transmit-empty, break, receive-full and data-ready. Software clears each flag by writing a zero to its bit. Hardware sets a flag through transmitter, receiver and line events. Writing a byte to the transmit data slot hands it to the serializer with a one-cycle strobe. The receive storage lives outside the block. The block reads its occupancy and head byte, and drives a pop strobe and a flush strobe into it. Two interrupt outputs go to the interrupt controller, one for transmit and one for receive.

Top module: `serctl_regs`

## Requirements
- R1: After reset, mode reads 0x00, bit rate 0xFF, control 0x20, FIFO control 0x0000 and port 0x00. Status reads 0x60, meaning transmit-end and transmit-empty are set. Both interrupt outputs and `rx_enable` are low.
- R2: Writes are masked before they are stored: mode with 0x7B, control with 0xFA and port with 0xF3. The bit-rate register stores all 8 bits.
- R3: Status reads as bit 6 transmit-end, bit 5 transmit-empty, bit 4 break, bit 1 receive-full and bit 0 data-ready; every other bit reads 0. In a status write, a 0 in one of these bits clears that flag and a 1 leaves it unchanged.
- R4: A status write that has bit 1 or bit 0 at zero drops `irq_rx`.
- R5: Control bit 7 is transmit interrupt enable, bit 6 receive interrupt enable, bit 5 transmit enable and bit 4 receive enable. `irq_tx` equals control bit 7 and `rx_enable` equals control bit 4. A control write with bit 5 at zero sets transmit-end. A control write with bit 6 at zero drops `irq_rx`.
- R6: A write to offset 0x0C raises `tx_strobe` for exactly one cycle, with `tx_byte` holding the written byte, and clears transmit-empty. Reads of 0x0C return 0.
- R7: A status read while control bit 5 is set returns the flags as they were, then sets transmit-empty and transmit-end. With bit 5 clear, a status read changes nothing.
- R8: FIFO control bits 7:6 select the receive trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. A receive arrival that brings the occupancy to the trigger level or above sets receive-full. If control bit 6 is also set, it raises `irq_rx`.
- R9: A read of offset 0x14 with a nonempty FIFO returns `rx_byte` and pulses `rx_pop` in that access cycle. It clears receive-full if the occupancy after the pop is below the trigger level. With an empty FIFO the read returns 0 and does not pop.
- R10: FIFO control stores 16 bits and reads back unchanged. A write with bit 1 set pulses `rx_flush` in that access cycle. Offset 0x1C reads the current `rx_level`.
- R11: Line status (0x24), unmapped offsets and misaligned addresses read 0. Writes to them change no register or flag.
- R12: `rd_valid` is high exactly one cycle after each read access, with `rd_data` valid, and is low after writes and idle cycles.
- R13: A `brk_evt` pulse sets break and a `dr_evt` pulse sets data-ready. Hardware sets take priority over software clears that fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the register slot |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| tx_byte | output | 8 | Byte handed to the serializer |
| tx_strobe | output | 1 | One-cycle strobe: tx_byte is new |
| rx_enable | output | 1 | Receiver enable (control bit 4) |
| rx_level | input | CNT_W | Current receive FIFO occupancy |
| rx_byte | input | 8 | Receive FIFO head byte |
| rx_arrive | input | 1 | A byte is being pushed into the receive FIFO |
| rx_pop | output | 1 | Pop the receive FIFO head (same cycle as the read) |
| rx_flush | output | 1 | Empty the receive FIFO |
| brk_evt | input | 1 | Break condition detected |
| dr_evt | input | 1 | Data-ready condition detected |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its defaults: a 6-bit address (sixteen slots, six of them unmapped), a 16-bit data path and a 16-entry FIFO depth, which gives a 5-bit occupancy. The wide address makes the unmapped and misaligned slots reachable. The 5-bit occupancy lets the bench present levels up to 14, so the highest trigger threshold is crossed exactly at its boundary (13 then 14). A queue-driven scoreboard follows every read through the one-cycle return path. It covers the status re-arm with the transmitter on and off, pops at and above the trigger, and an empty pop.

// File: rtl/serctl_pkg.sv
`timescale 1ns/1ps
package serctl_pkg;

   // register slots, index = byte offset / 4
   localparam int REG_SLOTS = 10;

   typedef enum logic [3:0] {
      SEL_MODE  = 4'd0,
      SEL_RATE  = 4'd1,
      SEL_CTRL  = 4'd2,
      SEL_TXD   = 4'd3,
      SEL_STAT  = 4'd4,
      SEL_RXD   = 4'd5,
      SEL_FCTL  = 4'd6,
      SEL_FCNT  = 4'd7,
      SEL_PORT  = 4'd8,
      SEL_LSTAT = 4'd9,
      SEL_NONE  = 4'd15
   } reg_sel_e;

   localparam logic [7:0] MODE_MASK = 8'h7B;
   localparam logic [7:0] CTRL_MASK = 8'hFA;
   localparam logic [7:0] PORT_MASK = 8'hF3;
   localparam logic [7:0] RATE_RST  = 8'hFF;
   localparam logic [7:0] CTRL_RST  = 8'h20;

   // control bits
   localparam int CB_TXIE = 7;
   localparam int CB_RXIE = 6;
   localparam int CB_TXEN = 5;
   localparam int CB_RXEN = 4;

   // status image bits
   localparam int SB_TEND = 6;
   localparam int SB_TDE  = 5;
   localparam int SB_BRK  = 4;
   localparam int SB_RDF  = 1;
   localparam int SB_DR   = 0;

   // FIFO control bits
   localparam int FB_FLUSH  = 1;
   localparam int FB_TRG_LO = 6;

   typedef struct packed {
      logic tend;
      logic tde;
      logic brk;
      logic rdf;
      logic dr;
   } flags_t;

   function automatic logic [7:0] stat_image(flags_t f);
      logic [7:0] v;
      v          = '0;
      v[SB_TEND] = f.tend;
      v[SB_TDE]  = f.tde;
      v[SB_BRK]  = f.brk;
      v[SB_RDF]  = f.rdf;
      v[SB_DR]   = f.dr;
      return v;
   endfunction

endpackage

// File: rtl/serctl_decode.sv
`timescale 1ns/1ps
module serctl_decode
   import serctl_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam int SLOT_W = ADDR_W - 2;

   if ((1 << SLOT_W) < REG_SLOTS) begin : g_bad_addr
      $error("serctl_decode: ADDR_W too small for the register map");
   end

   logic [REG_SLOTS-1:0] hit;

   for (genvar i = 0; i < REG_SLOTS; i++) begin : g_slot
      assign hit[i] = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] == SLOT_W'(i));
   end

   always_comb begin
      sel = SEL_NONE;
      for (int i = 0; i < REG_SLOTS; i++) begin
         if (hit[i]) sel = reg_sel_e'(4'(i));
      end
   end

endmodule

// File: rtl/serctl_trig.sv
`timescale 1ns/1ps
module serctl_trig #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic [1:0]       code,
   output logic [CNT_W-1:0] level
);
   localparam int LV [4] = '{1, 4, 8, 14};

   logic [CNT_W-1:0] tbl [4];

   for (genvar k = 0; k < 4; k++) begin : g_lvl
      if (LV[k] > DEPTH) begin : g_bad
         $error("serctl_trig: trigger level exceeds FIFO depth");
      end
      assign tbl[k] = CNT_W'(LV[k]);
   end

   assign level = tbl[code];

endmodule

// File: rtl/serctl_flags.sv
`timescale 1ns/1ps
module serctl_flags
   import serctl_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stat_wr,
   input  logic             stat_rd,
   input  logic             ctrl_wr,
   input  logic             txd_wr,
   input  logic [7:0]       wbyte,
   input  logic             tx_on,
   input  logic             rxie,
   input  logic             arrive,
   input  logic             brk_evt,
   input  logic             dr_evt,
   input  logic             pop,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] trig,
   output flags_t           flags,
   output logic             irq_rx
);
   localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

   logic [CNT_W:0] lvl_push, lvl_pop, trig_x;
   logic           reach, drop;
   flags_t         nxt;
   logic           irq_nxt;

   assign trig_x   = {1'b0, trig};
   assign lvl_push = {1'b0, level} + ONE;
   assign lvl_pop  = {1'b0, level} - ONE;
   assign reach    = arrive && (lvl_push >= trig_x);
   assign drop     = pop && (lvl_pop < trig_x);

   // clears first, hardware sets last so they win
   always_comb begin
      nxt = flags;
      if (stat_wr) begin
         if (!wbyte[SB_TEND]) nxt.tend = 1'b0;
         if (!wbyte[SB_TDE])  nxt.tde  = 1'b0;
         if (!wbyte[SB_BRK])  nxt.brk  = 1'b0;
         if (!wbyte[SB_RDF])  nxt.rdf  = 1'b0;
         if (!wbyte[SB_DR])   nxt.dr   = 1'b0;
      end
      if (txd_wr) nxt.tde = 1'b0;
      if (drop)   nxt.rdf = 1'b0;
      if (ctrl_wr && !wbyte[CB_TXEN]) nxt.tend = 1'b1;
      if (stat_rd && tx_on) begin
         nxt.tde  = 1'b1;
         nxt.tend = 1'b1;
      end
      if (reach)   nxt.rdf = 1'b1;
      if (brk_evt) nxt.brk = 1'b1;
      if (dr_evt)  nxt.dr  = 1'b1;
   end

   always_comb begin
      irq_nxt = irq_rx;
      if (stat_wr && (!wbyte[SB_RDF] || !wbyte[SB_DR])) irq_nxt = 1'b0;
      if (ctrl_wr && !wbyte[CB_RXIE])                   irq_nxt = 1'b0;
      if (reach && rxie)                                irq_nxt = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
         irq_rx <= 1'b0;
      end else begin
         flags  <= nxt;
         irq_rx <= irq_nxt;
      end
   end

endmodule

// File: rtl/serctl_regs.sv
`timescale 1ns/1ps
module serctl_regs
   import serctl_pkg::*;
#(
   parameter  int ADDR_W = 6,
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [7:0]        tx_byte,
   output logic              tx_strobe,
   output logic              rx_enable,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic [7:0]        rx_byte,
   input  logic              rx_arrive,
   output logic              rx_pop,
   output logic              rx_flush,
   input  logic              brk_evt,
   input  logic              dr_evt,
   output logic              irq_tx,
   output logic              irq_rx
);
   localparam int FCTL_W = 16;

   if (DATA_W < FCTL_W) begin : g_bad_data
      $error("serctl_regs: DATA_W must hold the FIFO control register");
   end
   if (DEPTH < 14) begin : g_bad_depth
      $error("serctl_regs: DEPTH must reach the highest trigger level");
   end

   reg_sel_e          sel;
   logic              wr_acc, rd_acc;
   logic [7:0]        mode_q, rate_q, ctrl_q, port_q, txd_q;
   logic [FCTL_W-1:0] fctl_q;
   logic              tx_strobe_q, rd_valid_q;
   logic [DATA_W-1:0] rd_data_q, rd_mux;
   logic [CNT_W-1:0]  trig_lvl;
   flags_t            flags_w;
   logic              stat_wr, stat_rd, ctrl_wr, txd_wr;

   assign wr_acc  = acc_en &  acc_wr;
   assign rd_acc  = acc_en & ~acc_wr;
   assign stat_wr = wr_acc && (sel == SEL_STAT);
   assign stat_rd = rd_acc && (sel == SEL_STAT);
   assign ctrl_wr = wr_acc && (sel == SEL_CTRL);
   assign txd_wr  = wr_acc && (sel == SEL_TXD);

   serctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (acc_addr),
      .sel  (sel)
   );

   serctl_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
      .code  (fctl_q[FB_TRG_LO+1:FB_TRG_LO]),
      .level (trig_lvl)
   );

   serctl_flags #(.CNT_W(CNT_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_wr (stat_wr),
      .stat_rd (stat_rd),
      .ctrl_wr (ctrl_wr),
      .txd_wr  (txd_wr),
      .wbyte   (acc_wdata[7:0]),
      .tx_on   (ctrl_q[CB_TXEN]),
      .rxie    (ctrl_q[CB_RXIE]),
      .arrive  (rx_arrive),
      .brk_evt (brk_evt),
      .dr_evt  (dr_evt),
      .pop     (rx_pop),
      .level   (rx_level),
      .trig    (trig_lvl),
      .flags   (flags_w),
      .irq_rx  (irq_rx)
   );

   assign rx_pop   = rd_acc && (sel == SEL_RXD) && (rx_level != '0);
   assign rx_flush = wr_acc && (sel == SEL_FCTL) && acc_wdata[FB_FLUSH];

   always_comb begin
      case (sel)
         SEL_MODE: rd_mux = DATA_W'(mode_q);
         SEL_RATE: rd_mux = DATA_W'(rate_q);
         SEL_CTRL: rd_mux = DATA_W'(ctrl_q);
         SEL_STAT: rd_mux = DATA_W'(stat_image(flags_w));
         SEL_RXD:  rd_mux = (rx_level != '0) ? DATA_W'(rx_byte) : '0;
         SEL_FCTL: rd_mux = DATA_W'(fctl_q);
         SEL_FCNT: rd_mux = DATA_W'(rx_level);
         SEL_PORT: rd_mux = DATA_W'(port_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= '0;
         rate_q      <= RATE_RST;
         ctrl_q      <= CTRL_RST;
         port_q      <= '0;
         fctl_q      <= '0;
         txd_q       <= '0;
         tx_strobe_q <= 1'b0;
         rd_valid_q  <= 1'b0;
         rd_data_q   <= '0;
      end else begin
         tx_strobe_q <= txd_wr;
         rd_valid_q  <= rd_acc;
         if (rd_acc) rd_data_q <= rd_mux;
         if (wr_acc) begin
            case (sel)
               SEL_MODE: mode_q <= acc_wdata[7:0] & MODE_MASK;
               SEL_RATE: rate_q <= acc_wdata[7:0];
               SEL_CTRL: ctrl_q <= acc_wdata[7:0] & CTRL_MASK;
               SEL_TXD:  txd_q  <= acc_wdata[7:0];
               SEL_FCTL: fctl_q <= acc_wdata[FCTL_W-1:0];
               SEL_PORT: port_q <= acc_wdata[7:0] & PORT_MASK;
               default:  ;
            endcase
         end
      end
   end

   assign rd_data   = rd_data_q;
   assign rd_valid  = rd_valid_q;
   assign tx_byte   = txd_q;
   assign tx_strobe = tx_strobe_q;
   assign rx_enable = ctrl_q[CB_RXEN];
   assign irq_tx    = ctrl_q[CB_TXIE];

endmodule

// File: rtl/serctl_chk.sv
`timescale 1ns/1ps
module serctl_chk
   import serctl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        wbyte,
   input logic              rd_valid,
   input logic              tx_strobe,
   input logic [7:0]        tx_byte,
   input logic              irq_tx,
   input logic              irq_rx,
   input logic              rx_pop,
   input logic              rx_arrive,
   input logic              brk_evt,
   input logic              dr_evt,
   input logic [CNT_W-1:0]  rx_level,
   input flags_t            flags,
   input logic [7:0]        ctrl
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(8'h0C);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h10);

   logic rd_a, wr_ctrl, wr_txd, wr_stat, rd_stat;
   assign rd_a    = acc_en && !acc_wr;
   assign wr_ctrl = acc_en && acc_wr && (acc_addr == A_CTRL);
   assign wr_txd  = acc_en && acc_wr && (acc_addr == A_TXD);
   assign wr_stat = acc_en && acc_wr && (acc_addr == A_STAT);
   assign rd_stat = rd_a && (acc_addr == A_STAT);

   p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_a |=> rd_valid);
   p_no_stray_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_a |=> !rd_valid);
   p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl == ($past(wbyte) & 8'hFA)));
   p_txirq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (irq_tx == $past(wbyte[7])));
   p_tx_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txd |=> (tx_strobe && tx_byte == $past(wbyte) && !flags.tde));
   p_tend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wbyte[6]) |=> !flags.tend);
   p_rdf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wbyte[1] && !rx_arrive) |=> !flags.rdf);
   p_rxirq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (!wbyte[1] || !wbyte[0]) && !rx_arrive) |=> !irq_rx);
   p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ctrl[5]) |=> (flags.tde && flags.tend));
   p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> (rx_level != '0));
   p_brk_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> flags.brk);
   p_dr_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
      dr_evt |=> flags.dr);

endmodule

bind serctl_regs serctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .wbyte     (acc_wdata[7:0]),
   .rd_valid  (rd_valid),
   .tx_strobe (tx_strobe),
   .tx_byte   (tx_byte),
   .irq_tx    (irq_tx),
   .irq_rx    (irq_rx),
   .rx_pop    (rx_pop),
   .rx_arrive (rx_arrive),
   .brk_evt   (brk_evt),
   .dr_evt    (dr_evt),
   .rx_level  (rx_level),
   .flags     (flags_w),
   .ctrl      (ctrl_q)
);

// File: tb/serctl_regs_tb_top.sv
`timescale 1ns/1ps
module serctl_regs_tb_top;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n, acc_en, acc_wr;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_wdata, rd_data;
   logic              rd_valid, tx_strobe, rx_enable;
   logic [7:0]        tx_byte, rx_byte;
   logic [CNT_W-1:0]  rx_level;
   logic              rx_arrive, rx_pop, rx_flush, brk_evt, dr_evt, irq_tx, irq_rx;

   int    total = 0, bad = 0;
   bit    done = 0;
   int    exp_q[$];
   string tag_q[$];
   int    pop_cnt = 0, flush_cnt = 0;

   always #2.5 clk = ~clk;

   serctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .rd_valid(rd_valid), .tx_byte(tx_byte), .tx_strobe(tx_strobe),
      .rx_enable(rx_enable), .rx_level(rx_level), .rx_byte(rx_byte),
      .rx_arrive(rx_arrive), .rx_pop(rx_pop), .rx_flush(rx_flush),
      .brk_evt(brk_evt), .dr_evt(dr_evt), .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as read data comes back
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R12: actual=read 0x%0h expected=no read pending", rd_data);
         end else begin
            string t;
            int    e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            check(t, 32'(rd_data), 32'(e));
         end
      end
   end

   always @(posedge clk) begin
      if (rx_pop)   pop_cnt++;
      if (rx_flush) flush_cnt++;
   end

   task automatic access(bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      acc_en = 1'b1; acc_wr = w; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      access(1'b1, a, d);
      check("R12 no valid after write", 32'(rd_valid), 32'd0);
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, int e, string req);
      exp_q.push_back(e);
      tag_q.push_back(req);
      access(1'b0, a, '0);
   endtask

   task automatic arrive(int lvl);
      rx_level = CNT_W'(lvl); rx_arrive = 1'b1;
      @(negedge clk);
      rx_arrive = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int p0, f0;
      rst_n = 0; acc_en = 0; acc_wr = 0; acc_addr = '0; acc_wdata = '0;
      rx_level = '0; rx_byte = '0; rx_arrive = 0; brk_evt = 0; dr_evt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq_tx", 32'(irq_tx), 0);
      check("R1 irq_rx", 32'(irq_rx), 0);
      check("R1 rx_enable", 32'(rx_enable), 0);
      check("R1 tx_strobe", 32'(tx_strobe), 0);
      check("R12 idle valid", 32'(rd_valid), 0);
      rd(6'h00, 'h00, "R1 mode");
      rd(6'h04, 'hFF, "R1 rate");
      rd(6'h08, 'h20, "R1 ctrl");
      rd(6'h10, 'h60, "R1 status");
      rd(6'h18, 'h00, "R1 fifo ctrl");
      rd(6'h20, 'h00, "R1 port");

      // R2 masks
      wr(6'h00, 'hFF); rd(6'h00, 'h7B, "R2 mode mask");
      wr(6'h20, 'hFF); rd(6'h20, 'hF3, "R2 port mask");
      wr(6'h04, 'h12); rd(6'h04, 'h12, "R2 rate");
      wr(6'h08, 'hFF); rd(6'h08, 'hFA, "R2 ctrl mask");
      check("R5 irq_tx follows bit7", 32'(irq_tx), 1);
      check("R5 rx_enable follows bit4", 32'(rx_enable), 1);

      // R6 transmit, R7 re-arm
      wr(6'h0C, 'hA5);
      check("R6 tx_strobe", 32'(tx_strobe), 1);
      check("R6 tx_byte", 32'(tx_byte), 'hA5);
      rd(6'h10, 'h40, "R6 tde cleared");
      check("R6 strobe one cycle", 32'(tx_strobe), 0);
      rd(6'h10, 'h60, "R7 rearm after read");
      rd(6'h0C, 'h00, "R6 txd reads zero");

      // R3 write-zero clear
      wr(6'h10, 'h00);
      rd(6'h10, 'h00, "R3 all cleared");
      rd(6'h10, 'h60, "R7 rearm again");

      // R13 events, R3 write-one keeps
      brk_evt = 1; dr_evt = 1; @(negedge clk); brk_evt = 0; dr_evt = 0;
      rd(6'h10, 'h71, "R13 brk and dr set");
      wr(6'h10, 'hEF); rd(6'h10, 'h61, "R3 clear brk only");
      wr(6'h10, 'hFE); rd(6'h10, 'h60, "R3 clear dr only");

      // R5 / R7 with transmitter off
      wr(6'h08, 'h40);
      check("R5 irq_tx low", 32'(irq_tx), 0);
      check("R5 rx_enable low", 32'(rx_enable), 0);
      wr(6'h10, 'h00);
      rd(6'h10, 'h00, "R7 no rearm tx off");
      rd(6'h10, 'h00, "R7 still no rearm");
      wr(6'h08, 'h40);
      rd(6'h10, 'h40, "R5 ctrl write sets tend");

      // R8 trigger 4
      wr(6'h18, 'h40); rd(6'h18, 'h40, "R10 fifo ctrl readback");
      arrive(0); arrive(1); arrive(2);
      check("R8 below trigger no irq", 32'(irq_rx), 0);
      rd(6'h10, 'h40, "R8 below trigger");
      arrive(3);
      check("R8 trigger irq", 32'(irq_rx), 1);
      rd(6'h10, 'h42, "R8 at trigger");

      // R9 pops
      rx_level = 5'd4; rx_byte = 'h3C; p0 = pop_cnt;
      rd(6'h14, 'h3C, "R9 pop data");
      check("R9 pop strobe", 32'(pop_cnt - p0), 1);
      rd(6'h10, 'h40, "R9 rdf cleared below trigger");
      rx_level = '0; p0 = pop_cnt;
      rd(6'h14, 'h00, "R9 empty read");
      check("R9 no pop when empty", 32'(pop_cnt - p0), 0);
      arrive(5);
      rx_level = 5'd6; rx_byte = 'h5A;
      rd(6'h14, 'h5A, "R9 pop data 2");
      rd(6'h10, 'h42, "R9 rdf kept at trigger");

      // R4
      wr(6'h10, 'hFD);
      check("R4 status write drops irq_rx", 32'(irq_rx), 0);
      rd(6'h10, 'h40, "R4 rdf cleared");

      // R5 control bit6 drop
      arrive(3);
      check("R8 irq again", 32'(irq_rx), 1);
      wr(6'h08, 'h00);
      check("R5 ctrl write drops irq_rx", 32'(irq_rx), 0);
      rd(6'h10, 'h42, "R5 rdf stays");
      wr(6'h10, 'hFD);

      // R10 flush, R8 other triggers
      f0 = flush_cnt;
      wr(6'h18, 'h02);
      check("R10 flush pulse", 32'(flush_cnt - f0), 1);
      arrive(0);
      check("R8 irq gated by bit6", 32'(irq_rx), 0);
      rd(6'h10, 'h42, "R8 trigger 1");
      rd(6'h18, 'h02, "R10 fifo ctrl 2");
      wr(6'h10, 'hFD);
      f0 = flush_cnt;
      wr(6'h18, 'hC0);
      check("R10 no flush bit1 zero", 32'(flush_cnt - f0), 0);
      arrive(12);
      rd(6'h10, 'h40, "R8 trigger 14 below");
      arrive(13);
      rd(6'h10, 'h42, "R8 trigger 14 reached");
      rx_level = 5'd9;
      rd(6'h1C, 9, "R10 count read");

      // R11 unmapped / line status / misaligned
      rd(6'h24, 'h00, "R11 line status");
      wr(6'h24, 'hFF); wr(6'h28, 'hFF); wr(6'h09, 'hFF); wr(6'h3C, 'hFF);
      rd(6'h28, 'h00, "R11 unmapped read");
      rd(6'h01, 'h00, "R11 misaligned read");
      rd(6'h00, 'h7B, "R11 mode untouched");
      rd(6'h08, 'h00, "R11 ctrl untouched");
      rd(6'h10, 'h42, "R11 flags untouched");
      check("R11 irq_tx untouched", 32'(irq_tx), 0);

      @(negedge clk);
      check("R12 all reads returned", 32'(exp_q.size()), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule